// File: doc/BRIEF.md
# Associative TLB Lookup Unit

This block translates 32-bit virtual addresses through a small, fully associative table. Each table entry covers a pair of adjacent 4 KB virtual pages, one even and one odd. Each half of the pair has its own physical frame number, valid bit and dirty bit. A lookup presents a virtual address, the current 8-bit address space identifier and a read/write flag. Within the same cycle the block returns a physical address, a write-permission flag and a two-bit fault code.

Entries are loaded one at a time through an indexed write port, and the load takes effect at the next clock edge. Refill policy and replacement choice belong to the surrounding logic. When more than one entry matches, the block always uses the match with the lowest index.

Top module: `xlate_tlb`

## Requirements
- R1: The compared virtual tag is address bits 31:13, so an entry with tag T serves every address whose upper 19 bits equal T, on both the even and the odd page.
- R2: An entry matches only when its tag equals the address tag and either its global bit is set or its stored 8-bit identifier equals the lookup identifier.
- R3: Address bit 12 selects the half of the matching entry (0 even, 1 odd), and that half supplies the frame number, the valid bit and the dirty bit.
- R4: If the selected half is not valid, the fault code is 2 (invalid) for both reads and writes.
- R5: A write to a valid half whose dirty bit is clear gives fault code 3 (modified). A read of a valid half always gives fault code 0 (none).
- R6: When the fault code is 0, the physical address is {frame, vaddr[11:0]} and writeOk equals the selected dirty bit. For any other fault code, the physical address and writeOk are both 0.
- R7: When no entry matches, the fault code is 1 (miss).
- R8: When several entries match, the entry with the lowest index supplies the result.
- R9: A write with wrEn high updates entry wrIdx at the next rising clock edge. A lookup in the same cycle still sees the old contents.
- R10: An active-low reset clears every field of every entry to zero. After reset, a lookup with a non-zero tag misses, and a lookup with tag 0 and identifier 0 reports invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| vaddr | input | 32 | Lookup virtual address |
| asid | input | 8 | Current address space identifier |
| isWrite | input | 1 | 1 for a store access, 0 for a load |
| physAddr | output | 32 | Translated address, 0 on any fault |
| writeOk | output | 1 | Write permission of the selected half on success |
| fault | output | 2 | 0 none, 1 miss, 2 invalid, 3 modified |
| wrEn | input | 1 | Entry load strobe |
| wrIdx | input | 3 | Entry index to load |
| wrTag | input | 19 | Tag (virtual bits 31:13) to store |
| wrAsid | input | 8 | Identifier to store |
| wrGlobal | input | 1 | Global bit to store |
| wrPfnEven | input | 20 | Frame number for the even page |
| wrPfnOdd | input | 20 | Frame number for the odd page |
| wrValidEven | input | 1 | Valid bit, even page |
| wrValidOdd | input | 1 | Valid bit, odd page |
| wrDirtyEven | input | 1 | Dirty bit, even page |
| wrDirtyOdd | input | 1 | Dirty bit, odd page |

## Verification
A lookup and an entry load can occur in the same cycle, and both can target the same entry. The bench provokes this by driving the load inputs and a lookup on that entry's address at the same time, between clock edges. The result is judged first before the edge, where the old mapping and fault must still be visible, and then after the edge, where the new frame and permission must be visible. Priority among overlapping entries is exercised separately: a lower-index duplicate is rewritten, and the bench checks that the winner moves to the next matching entry.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  typedef enum logic [1:0] {
    FLT_NONE     = 2'd0,
    FLT_MISS     = 2'd1,
    FLT_INVALID  = 2'd2,
    FLT_MODIFIED = 2'd3
  } tlbFault_t;

  // Per-entry strobes from control to datapath
  typedef struct packed {
    logic load;  // capture write-port data this edge
    logic win;   // this entry supplies the lookup result
  } entryCtl_t;

endpackage

// File: rtl/xlate_tlb_dp.sv
module xlate_tlb_dp
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 20
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  entryCtl_t [ENTRIES-1:0]  ctl,
  input  logic                     pass,
  input  logic [VA_W-1:0]          vaddr,
  input  logic [ASID_W-1:0]        asid,
  input  logic [VA_W-14:0]         wrTag,
  input  logic [ASID_W-1:0]        wrAsid,
  input  logic                     wrGlobal,
  input  logic [PFN_W-1:0]         wrPfnEven,
  input  logic [PFN_W-1:0]         wrPfnOdd,
  input  logic                     wrValidEven,
  input  logic                     wrValidOdd,
  input  logic                     wrDirtyEven,
  input  logic                     wrDirtyOdd,
  output logic [ENTRIES-1:0]       matchVec,
  output logic                     selValid,
  output logic                     selDirty,
  output logic [PFN_W+11:0]        physAddr,
  output logic                     writeOk
);

  localparam int TAG_W = VA_W - 13;

  logic [TAG_W-1:0]  tagQ     [ENTRIES];
  logic [ASID_W-1:0] asidQ    [ENTRIES];
  logic              globalQ  [ENTRIES];
  logic [PFN_W-1:0]  pfnEvenQ [ENTRIES];
  logic [PFN_W-1:0]  pfnOddQ  [ENTRIES];
  logic              vEvenQ   [ENTRIES];
  logic              vOddQ    [ENTRIES];
  logic              dEvenQ   [ENTRIES];
  logic              dOddQ    [ENTRIES];

  logic [TAG_W-1:0] lookTag;
  logic             oddPage;
  logic [PFN_W-1:0] selPfn;

  assign lookTag = vaddr[VA_W-1:13];
  assign oddPage = vaddr[12];

  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        tagQ[g]     <= '0;
        asidQ[g]    <= '0;
        globalQ[g]  <= 1'b0;
        pfnEvenQ[g] <= '0;
        pfnOddQ[g]  <= '0;
        vEvenQ[g]   <= 1'b0;
        vOddQ[g]    <= 1'b0;
        dEvenQ[g]   <= 1'b0;
        dOddQ[g]    <= 1'b0;
      end else if (ctl[g].load) begin
        tagQ[g]     <= wrTag;
        asidQ[g]    <= wrAsid;
        globalQ[g]  <= wrGlobal;
        pfnEvenQ[g] <= wrPfnEven;
        pfnOddQ[g]  <= wrPfnOdd;
        vEvenQ[g]   <= wrValidEven;
        vOddQ[g]    <= wrValidOdd;
        dEvenQ[g]   <= wrDirtyEven;
        dOddQ[g]    <= wrDirtyOdd;
      end
    end

    assign matchVec[g] = (tagQ[g] == lookTag) &&
                         (globalQ[g] || (asidQ[g] == asid));
  end

  // AND-OR mux driven by the one-hot winner strobe
  always_comb begin
    selPfn   = '0;
    selValid = 1'b0;
    selDirty = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (ctl[i].win) begin
        selPfn   = selPfn   | (oddPage ? pfnOddQ[i] : pfnEvenQ[i]);
        selValid = selValid | (oddPage ? vOddQ[i]   : vEvenQ[i]);
        selDirty = selDirty | (oddPage ? dOddQ[i]   : dEvenQ[i]);
      end
    end
  end

  assign physAddr = pass ? {selPfn, vaddr[11:0]} : '0;
  assign writeOk  = pass & selDirty;

endmodule

// File: rtl/xlate_tlb_ctl.sv
module xlate_tlb_ctl
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                     wrEn,
  input  logic [IDX_W-1:0]         wrIdx,
  input  logic [ENTRIES-1:0]       matchVec,
  input  logic                     selValid,
  input  logic                     selDirty,
  input  logic                     isWrite,
  output entryCtl_t [ENTRIES-1:0]  ctl,
  output tlbFault_t                fault,
  output logic                     pass
);

  logic [ENTRIES-1:0] winVec;
  logic               hit;

  // Lowest index match takes the lookup
  always_comb begin
    winVec = '0;
    hit    = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (matchVec[i] && !hit) begin
        winVec[i] = 1'b1;
        hit       = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : gStrobe
    assign ctl[g].load = wrEn && (wrIdx == IDX_W'(g));
    assign ctl[g].win  = winVec[g];
  end

  always_comb begin
    if (!hit)                      fault = FLT_MISS;
    else if (!selValid)            fault = FLT_INVALID;
    else if (isWrite && !selDirty) fault = FLT_MODIFIED;
    else                           fault = FLT_NONE;
  end

  assign pass = (fault == FLT_NONE);

endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 20,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int TAG_W   = VA_W - 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [VA_W-1:0]   vaddr,
  input  logic [ASID_W-1:0] asid,
  input  logic              isWrite,
  output logic [PFN_W+11:0] physAddr,
  output logic              writeOk,
  output logic [1:0]        fault,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [TAG_W-1:0]  wrTag,
  input  logic [ASID_W-1:0] wrAsid,
  input  logic              wrGlobal,
  input  logic [PFN_W-1:0]  wrPfnEven,
  input  logic [PFN_W-1:0]  wrPfnOdd,
  input  logic              wrValidEven,
  input  logic              wrValidOdd,
  input  logic              wrDirtyEven,
  input  logic              wrDirtyOdd
);

  entryCtl_t [ENTRIES-1:0] ctl;
  logic [ENTRIES-1:0]      matchVec;
  logic                    selValid;
  logic                    selDirty;
  logic                    pass;
  tlbFault_t               faultCode;

  xlate_tlb_ctl #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ctl (
    .wrEn     (wrEn),
    .wrIdx    (wrIdx),
    .matchVec (matchVec),
    .selValid (selValid),
    .selDirty (selDirty),
    .isWrite  (isWrite),
    .ctl      (ctl),
    .fault    (faultCode),
    .pass     (pass)
  );

  xlate_tlb_dp #(.ENTRIES(ENTRIES), .VA_W(VA_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .pass        (pass),
    .vaddr       (vaddr),
    .asid        (asid),
    .wrTag       (wrTag),
    .wrAsid      (wrAsid),
    .wrGlobal    (wrGlobal),
    .wrPfnEven   (wrPfnEven),
    .wrPfnOdd    (wrPfnOdd),
    .wrValidEven (wrValidEven),
    .wrValidOdd  (wrValidOdd),
    .wrDirtyEven (wrDirtyEven),
    .wrDirtyOdd  (wrDirtyOdd),
    .matchVec    (matchVec),
    .selValid    (selValid),
    .selDirty    (selDirty),
    .physAddr    (physAddr),
    .writeOk     (writeOk)
  );

  assign fault = faultCode;

endmodule

// File: rtl/xlate_tlb_chk.sv
module xlate_tlb_chk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic [VA_W-1:0] vaddr,
  input logic            isWrite,
  input logic [PA_W-1:0] physAddr,
  input logic            writeOk,
  input logic [1:0]      fault
);

  AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (!rstN)
    (fault == 2'd0) |-> (physAddr[11:0] == vaddr[11:0])); // R6

  AST_FAULT_BLANKS: assert property (@(posedge clk) disable iff (!rstN)
    (fault != 2'd0) |-> (!writeOk && physAddr == '0)); // R6

  AST_WRITE_NEEDS_PERM: assert property (@(posedge clk) disable iff (!rstN)
    (fault == 2'd0 && isWrite) |-> writeOk); // R5

  AST_MODIFIED_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (fault == 2'd3) |-> isWrite); // R5

endmodule

bind xlate_tlb xlate_tlb_chk #(.VA_W(VA_W), .PA_W(PFN_W + 12)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .vaddr    (vaddr),
  .isWrite  (isWrite),
  .physAddr (physAddr),
  .writeOk  (writeOk),
  .fault    (fault)
);

// File: tb/test_xlate_tlb.sv
module test_xlate_tlb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] vaddr = '0;
  logic [7:0]  asid = '0;
  logic        isWrite = 1'b0;
  logic [31:0] physAddr;
  logic        writeOk;
  logic [1:0]  fault;
  logic        wrEn = 1'b0;
  logic [2:0]  wrIdx = '0;
  logic [18:0] wrTag = '0;
  logic [7:0]  wrAsid = '0;
  logic        wrGlobal = 1'b0;
  logic [19:0] wrPfnEven = '0;
  logic [19:0] wrPfnOdd = '0;
  logic        wrValidEven = 1'b0;
  logic        wrValidOdd = 1'b0;
  logic        wrDirtyEven = 1'b0;
  logic        wrDirtyOdd = 1'b0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlate_tlb i_xlate_tlb (
    .clk(clk), .rstN(rstN), .vaddr(vaddr), .asid(asid), .isWrite(isWrite),
    .physAddr(physAddr), .writeOk(writeOk), .fault(fault),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrTag(wrTag), .wrAsid(wrAsid), .wrGlobal(wrGlobal),
    .wrPfnEven(wrPfnEven), .wrPfnOdd(wrPfnOdd),
    .wrValidEven(wrValidEven), .wrValidOdd(wrValidOdd),
    .wrDirtyEven(wrDirtyEven), .wrDirtyOdd(wrDirtyOdd)
  );

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Drive a lookup, let combinational outputs settle, compare all three
  task automatic look(input string req, input logic [31:0] va, input logic [7:0] id,
                      input logic wr, input logic [1:0] expFault,
                      input logic [31:0] expPa, input logic expOk);
    vaddr = va; asid = id; isWrite = wr;
    #1;
    checks++;
    if (fault !== expFault || physAddr !== expPa || writeOk !== expOk) begin
      errors++;
      $display("FAIL %s va=%h: fault=%0d pa=%h ok=%b expected fault=%0d pa=%h ok=%b",
               req, va, fault, physAddr, writeOk, expFault, expPa, expOk);
    end
  endtask

  task automatic setEntry(input logic [2:0] idx, input logic [18:0] tag, input logic [7:0] id,
                          input logic g, input logic [19:0] pe, input logic [19:0] po,
                          input logic ve, input logic vo, input logic de, input logic dd);
    wrIdx = idx; wrTag = tag; wrAsid = id; wrGlobal = g;
    wrPfnEven = pe; wrPfnOdd = po;
    wrValidEven = ve; wrValidOdd = vo; wrDirtyEven = de; wrDirtyOdd = dd;
  endtask

  task automatic writeEntry(input logic [2:0] idx, input logic [18:0] tag, input logic [7:0] id,
                            input logic g, input logic [19:0] pe, input logic [19:0] po,
                            input logic ve, input logic vo, input logic de, input logic dd);
    setEntry(idx, tag, id, g, pe, po, ve, vo, de, dd);
    wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic testReset();
    // R10: all fields zero after reset
    look("R10 nonzero tag misses", 32'h1234_5000, 8'h05, 1'b0, 2'd1, 32'h0, 1'b0);
    look("R10 zero tag zero id invalid", 32'h0000_0010, 8'h00, 1'b0, 2'd2, 32'h0, 1'b0);
  endtask

  task automatic testBasic();
    writeEntry(3'd2, 19'h00201, 8'h07, 1'b0, 20'h11111, 20'h22222, 1'b1, 1'b1, 1'b1, 1'b0);
    look("R1 R6 even read", 32'h0040_2abc, 8'h07, 1'b0, 2'd0, 32'h1111_1abc, 1'b1);
    look("R3 odd read uses odd frame and clean bit", 32'h0040_3def, 8'h07, 1'b0, 2'd0, 32'h2222_2def, 1'b0);
    look("R5 write to clean odd half", 32'h0040_3000, 8'h07, 1'b1, 2'd3, 32'h0, 1'b0);
    look("R5 write to dirty even half", 32'h0040_2004, 8'h07, 1'b1, 2'd0, 32'h1111_1004, 1'b1);
    look("R2 R7 identifier mismatch misses", 32'h0040_2abc, 8'h08, 1'b0, 2'd1, 32'h0, 1'b0);
    look("R1 R7 neighbour tag misses", 32'h0040_4abc, 8'h07, 1'b0, 2'd1, 32'h0, 1'b0);
  endtask

  task automatic testGlobal();
    writeEntry(3'd3, 19'h00300, 8'h01, 1'b1, 20'hAAAAA, 20'hBBBBB, 1'b0, 1'b1, 1'b1, 1'b1);
    look("R2 global ignores identifier", 32'h0060_1123, 8'h55, 1'b1, 2'd0, 32'hBBBB_B123, 1'b1);
    look("R4 invalid even half on read", 32'h0060_0123, 8'h55, 1'b0, 2'd2, 32'h0, 1'b0);
    look("R4 invalid even half on write", 32'h0060_0123, 8'h01, 1'b1, 2'd2, 32'h0, 1'b0);
  endtask

  task automatic testPriority();
    writeEntry(3'd6, 19'h7FFFF, 8'h00, 1'b1, 20'h66666, 20'h66667, 1'b1, 1'b1, 1'b0, 1'b0);
    writeEntry(3'd5, 19'h7FFFF, 8'h00, 1'b1, 20'h55555, 20'h55556, 1'b1, 1'b1, 1'b0, 1'b0);
    look("R8 lowest index wins", 32'hFFFF_E010, 8'h09, 1'b0, 2'd0, 32'h5555_5010, 1'b0);
    writeEntry(3'd5, 19'h00001, 8'h00, 1'b1, 20'h55555, 20'h55556, 1'b1, 1'b1, 1'b0, 1'b0);
    look("R8 next match after rewrite", 32'hFFFF_F020, 8'h09, 1'b0, 2'd0, 32'h6666_7020, 1'b0);
  endtask

  task automatic testSameCycle();
    // R9: load entry 2 with a new mapping while looking it up
    @(negedge clk);
    setEntry(3'd2, 19'h00201, 8'h07, 1'b0, 20'h33333, 20'h44444, 1'b1, 1'b1, 1'b1, 1'b1);
    wrEn = 1'b1;
    look("R9 old contents before edge", 32'h0040_3000, 8'h07, 1'b1, 2'd3, 32'h0, 1'b0);
    @(posedge clk); #1;
    wrEn = 1'b0;
    look("R9 new contents after edge", 32'h0040_3000, 8'h07, 1'b1, 2'd0, 32'h4444_4000, 1'b1);
    look("R9 R3 new even frame", 32'h0040_2fff, 8'h07, 1'b0, 2'd0, 32'h3333_3fff, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    @(posedge clk); @(posedge clk); #1;
    rstN = 1'b1;
    testReset();
    testBasic();
    testGlobal();
    testPriority();
    testSameCycle();
    finishRun();
  end

endmodule